// File: doc/BRIEF.md
# Switch Activation Order Recorder

This block watches a bank of on/off switch inputs, all of which begin in the OFF state. It produces the sequence of switch indices in the order the switches first turn ON. Each input is brought through a register chain. The last synchronized copy is then compared with a copy delayed by one more cycle, which finds OFF-to-ON edges. Every switch that has not yet been reported and shows such an edge becomes pending. A lowest-index-first priority encoder drains the pending set, one index per clock cycle. Each index comes with a valid strobe.

Switches that rise in the same sample form a group. Every member of the group is reported, in ascending index order. A flag on each of these outputs marks the index as part of a simultaneous group, so a host reading the stream can tell "came before" apart from "came together". Once a switch has been reported, it stays silent: it may go OFF and ON again any number of times without producing output. A done flag rises when every switch has been reported. Reset clears all recorded state so capture can start again.

Top module: `switch_order_recorder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, idx_valid, simul_flag and all_done are 0.
- R2: When switch i goes from OFF (0) to ON (1) for the first time, exactly one idx_valid pulse occurs with idx_out equal to i. With SYNC_STAGES=2 the pulse falls in the cycle after the third rising clock edge that follows the change.
- R3: A switch that has already been reported produces no further idx_valid pulse when it goes OFF, and none when it later goes ON again.
- R4: When several unreported switches go ON in the same sample, each of them is reported exactly once. The reports come on consecutive valid cycles in ascending index order.
- R5: simul_flag is 1 together with an index whose switch rose in the same sample as at least one other newly rising switch. It is 0 for an index whose switch rose alone. simul_flag is never 1 without idx_valid.
- R6: all_done becomes 1 in the cycle in which the last of the NUM_SW switches is reported. It then stays 1 until reset, whatever the inputs do.
- R7: Reset clears the record. A switch that is still ON when rst_n is released counts as a new activation and is reported again.
- R8: A switch that rises while an earlier group is still being drained is queued and not lost. Pending switches are always served lowest index first, whatever their order of arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; restarts capture |
| sw_in | input | NUM_SW | Raw switch levels, 1 = ON |
| idx_out | output | IDX_W | Index of the switch being reported |
| idx_valid | output | 1 | idx_out holds a new report this cycle |
| simul_flag | output | 1 | Reported switch rose together with another |
| all_done | output | 1 | Every switch has been reported |

## Verification
The collision of interest is a new rising edge arriving while the encoder is still draining an earlier simultaneous group. The new switch then joins the pending set in the same cycle that another index is being emitted. This is provoked by raising switches 4 to 7 together and raising switch 0 one cycle later. The emitted stream must be 4, 0, 5, 6, 7: the lower index overtakes the rest of the group. The group members must carry the simultaneous flag and switch 0 must not. A second overlap, reset landing while switches are held ON, is judged by those switches being reported again after release.

// File: rtl/sor_pkg.sv
package sor_pkg;

   // Width of a switch index; never narrower than one bit.
   function automatic int unsigned idx_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sor_sync.sv
// Input register chain plus one delayed copy, giving an OFF-to-ON edge vector.
module sor_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sw_in,
   output logic [W-1:0] rise
);

   logic [STAGES-1:0][W-1:0] chain_q;
   logic [W-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q[0] <= sw_in;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
         prev_q <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/sor_prio_enc.sv
// Lowest-index-first priority encoder.
module sor_prio_enc #(
   parameter int unsigned W  = 8,
   parameter int unsigned IW = 3
) (
   input  logic [W-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);

   always_comb begin
      idx = '0;
      any = |req;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/sor_tracker.sv
// Pending / reported / group bookkeeping and the registered report stream.
module sor_tracker #(
   parameter int unsigned W  = 8,
   parameter int unsigned IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  rise,
   output logic [IW-1:0] idx_out,
   output logic          idx_valid,
   output logic          simul_flag,
   output logic          all_done
);

   logic [W-1:0]  reported_q, pending_q, grouped_q;
   logic [W-1:0]  new_edges, pend_all, grp_all, grant;
   logic          multi;
   logic [IW-1:0] enc_idx;
   logic          enc_any;

   // Edges from switches neither reported nor already waiting.
   assign new_edges = rise & ~reported_q & ~pending_q;
   assign multi     = (new_edges & (new_edges - W'(1))) != '0;
   assign pend_all  = pending_q | new_edges;
   assign grp_all   = grouped_q | (multi ? new_edges : '0);

   sor_prio_enc #(.W(W), .IW(IW)) u_enc (
      .req (pend_all),
      .idx (enc_idx),
      .any (enc_any)
   );

   assign grant = enc_any ? (W'(1) << enc_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reported_q <= '0;
         pending_q  <= '0;
         grouped_q  <= '0;
         idx_out    <= '0;
         idx_valid  <= 1'b0;
         simul_flag <= 1'b0;
         all_done   <= 1'b0;
      end else begin
         pending_q  <= pend_all & ~grant;
         grouped_q  <= grp_all & ~grant;
         reported_q <= reported_q | grant;
         idx_valid  <= enc_any;
         simul_flag <= enc_any & grp_all[enc_idx];
         all_done   <= &(reported_q | grant);
         if (enc_any) idx_out <= enc_idx;
      end
   end

endmodule

// File: rtl/switch_order_recorder.sv
module switch_order_recorder #(
   parameter int unsigned NUM_SW      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = sor_pkg::idx_width(NUM_SW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SW-1:0] sw_in,
   output logic [IDX_W-1:0]  idx_out,
   output logic              idx_valid,
   output logic              simul_flag,
   output logic              all_done
);

   generate
      if (NUM_SW < 2) begin : g_bad_num
         $error("NUM_SW must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [NUM_SW-1:0] rise;

   sor_sync #(.W(NUM_SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .sw_in (sw_in),
      .rise  (rise)
   );

   sor_tracker #(.W(NUM_SW), .IW(IDX_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise       (rise),
      .idx_out    (idx_out),
      .idx_valid  (idx_valid),
      .simul_flag (simul_flag),
      .all_done   (all_done)
   );

endmodule

// File: rtl/sor_checker.sv
module sor_checker #(
   parameter int unsigned NUM_SW = 8,
   localparam int unsigned IDX_W = sor_pkg::idx_width(NUM_SW)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_SW-1:0] sw_in,
   input logic [IDX_W-1:0]  idx_out,
   input logic              idx_valid,
   input logic              simul_flag,
   input logic              all_done
);

   logic [NUM_SW-1:0] seen_q, seen_now;
   logic              in_range;

   assign in_range = 32'(idx_out) < NUM_SW;
   assign seen_now = seen_q | ((idx_valid && in_range) ? (NUM_SW'(1) << idx_out) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else        seen_q <= seen_now;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!idx_valid && !simul_flag && !all_done)); // R1

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> in_range); // R2

   AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_valid && in_range) |-> !seen_q[idx_out]); // R3

   AST_SIMUL_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      simul_flag |-> idx_valid); // R5

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      all_done |=> all_done); // R6

   AST_DONE_MEANS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      all_done |-> (&seen_now)); // R6

endmodule

bind switch_order_recorder sor_checker #(.NUM_SW(NUM_SW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_in      (sw_in),
   .idx_out    (idx_out),
   .idx_valid  (idx_valid),
   .simul_flag (simul_flag),
   .all_done   (all_done)
);

// File: tb/switch_order_recorder_tb.sv
module switch_order_recorder_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int HOLD       = 14;
   localparam int ROWS       = 8;
   localparam logic [N-1:0] STIM [ROWS] = '{
      8'h04, 8'h00, 8'h04, 8'h51, 8'h55, 8'h57, 8'h00, 8'hFF };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] sw_in = '0;
   logic [2:0]   idx_out;
   logic         idx_valid, simul_flag, all_done;

   int checks = 0;
   int fails  = 0;

   int log_idx [64];
   int log_sim [64];
   int log_n = 0;
   int exp_idx [64];
   int exp_sim [64];
   int exp_n = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   switch_order_recorder #(.NUM_SW(N), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .idx_out(idx_out),
      .idx_valid(idx_valid), .simul_flag(simul_flag), .all_done(all_done));

   always @(negedge clk) begin
      if (idx_valid && log_n < 64) begin
         log_idx[log_n] = int'(idx_out);
         log_sim[log_n] = int'(simul_flag);
         log_n++;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // Compare the reports logged from position base against the expected list.
   task automatic compare_from(input int base, input string tag);
      check(log_n - base == exp_n, {tag, " report count"}, log_n - base, exp_n);
      for (int k = 0; k < exp_n && base + k < log_n; k++) begin
         check(log_idx[base+k] == exp_idx[k], {tag, " index"}, log_idx[base+k], exp_idx[k]);
         check(log_sim[base+k] == exp_sim[k], {tag, " simul"}, log_sim[base+k], exp_sim[k]);
      end
   endtask

   task automatic push_exp(input int i, input int s);
      exp_idx[exp_n] = i;
      exp_sim[exp_n] = s;
      exp_n++;
   endtask

   task automatic do_reset(input logic [N-1:0] held);
      @(negedge clk);
      sw_in = held;
      rst_n = 1'b0;
      wait_cycles(3);
      check(!idx_valid && !simul_flag && !all_done, "R1 outputs in reset",
            int'({idx_valid, simul_flag, all_done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!idx_valid && !all_done, "R1 outputs after release",
            int'({idx_valid, all_done}), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [N-1:0] seen;
      int base;
      seen = '0;
      do_reset('0);

      // Table walk: model says newly ON unreported switches are reported
      // ascending (R2, R4), flagged when two or more (R5); reported ones stay
      // silent (R3).
      for (int r = 0; r < ROWS; r++) begin
         logic [N-1:0] fresh;
         fresh = STIM[r] & ~seen;
         exp_n = 0;
         for (int i = 0; i < N; i++)
            if (fresh[i]) push_exp(i, ($countones(fresh) >= 2) ? 1 : 0);
         seen |= fresh;
         base = log_n;
         sw_in = STIM[r];
         wait_cycles(HOLD);
         compare_from(base, "R2 R3 R4 R5 table row");
         check(all_done == (seen == '1), "R6 done level", int'(all_done), int'(seen == '1));
      end

      // R6: done holds while all switches go OFF.
      sw_in = '0;
      wait_cycles(HOLD);
      check(all_done == 1'b1, "R6 done sticky", int'(all_done), 1);

      // R7: reset with switches 0 and 7 held ON; both reported again as a group.
      do_reset(8'h81);
      base = log_n;
      exp_n = 0;
      push_exp(0, 1);
      push_exp(7, 1);
      wait_cycles(HOLD);
      compare_from(base, "R7 rerecord after reset");
      check(all_done == 1'b0, "R7 done cleared", int'(all_done), 0);

      // R8: group 4..7, then switch 0 one cycle later; 0 overtakes 5,6,7.
      do_reset('0);
      wait_cycles(4);
      base = log_n;
      exp_n = 0;
      push_exp(4, 1);
      push_exp(0, 0);
      push_exp(5, 1);
      push_exp(6, 1);
      push_exp(7, 1);
      sw_in = 8'hF0;
      @(negedge clk);
      sw_in = 8'hF1;
      wait_cycles(HOLD);
      compare_from(base, "R8 arrival during drain");
      check(all_done == 1'b0, "R6 not done with switches left", int'(all_done), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule